// File: doc/BRIEF.md
# Transition-Tracking Symbol Timing Error Detector

This block produces the timing phase error for a symbol synchronizer that tracks data transitions. Each symbol holds a fixed, integer number of samples. The block gets in-phase subcarrier-channel samples along with their position inside the symbol. For each nominal symbol boundary it adds up the samples that fall inside a window of programmable half-width centred on that boundary. It keeps that sum until the hard decision for the symbol after the boundary arrives.

When that decision arrives, the block compares it with the previous decision to find the transition direction, which is +1, 0 or −1. It weights the held window sum by that direction and adds the result into an accumulator. After a programmable number of boundaries, the accumulated value is put out as the timing error word, together with a one-cycle ready flag, and the accumulator starts again from zero.

A small timing offset moves a data transition away from the window centre. The window sum then grows in proportion to the offset, and its sign combined with the transition sign gives the direction of the correction. The gain does not depend on the window width as long as the transition stays inside the window. The loop filter and the sample-clock oscillator sit outside this block.

Top module: `ssd_detector`

## Requirements
- R1: While `rst_ni` is low and directly after reset, `err_vld_o` is 0 and `err_o` is 0.
- R2: With effective half-width h, a sample with `valid_i` high contributes to a boundary's window sum only if its phase p meets p ≥ SPS−h (end of the earlier symbol) or p < h (start of the later symbol). Samples at any other phase have no effect on the error word.
- R3: A `half_win_i` value above SPS/2 acts exactly as SPS/2, in which case every sample belongs to some window.
- R4: `dec_i`=1 means a negative symbol and `dec_i`=0 a positive one. The transition direction is (s_next − s_prev)/2, where s=+1 for positive and −1 for negative. A negative-to-positive change adds the held window sum, a positive-to-negative change subtracts it, and equal decisions add 0.
- R5: A window closes at phase h−1, or at phase 0 when h=0. Its sum is held until the next `dec_valid_i` strobe. The first decision after reset only records a sign and adds no term.
- R6: Every `acc_len_i` weighted terms produce one error word equal to their sum. `acc_len_i`=0 is treated as 1.
- R7: `err_vld_o` is high for exactly the one cycle after the clock edge at which the last term of a group is taken. `err_o` keeps its value while `err_vld_o` is low, and the next group starts from zero.
- R8: With h=0 every window sum is zero, so every error word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe |
| sample_i | input | SW | In-phase subcarrier-channel sample, two's complement |
| phase_i | input | PW | Sample index inside the current symbol, 0..SPS−1 |
| half_win_i | input | HWW | Window half-width in samples, saturated to SPS/2 |
| dec_valid_i | input | 1 | Symbol decision strobe, given once per symbol after that symbol's window has closed |
| dec_i | input | 1 | Symbol decision: 1 negative, 0 positive |
| acc_len_i | input | LW | Number of boundaries per error word (0 means 1) |
| err_o | output | EW | Accumulated timing error word, two's complement |
| err_vld_o | output | 1 | One-cycle ready flag for `err_o` |

## Verification
Several rules hold on every cycle and are checked by assertions: a sample outside the window leaves the running window sum unchanged, a weighted term is always the held sum, its negation or zero, the ready flag appears only right after a decision strobe, and the error word does not change between ready flags. Whether a term carries the right direction, whether the window really sits where the half-width puts it once the clamp and the zero-width case are applied, whether the first decision is left out, and how terms are grouped by the accumulation length can only be shown by the bench. It sweeps every half-width, several accumulation lengths and three decision patterns, and compares each error word against a sum it computes itself.

// File: rtl/ssd_pkg.sv
package ssd_pkg;
  // ternary transition direction
  typedef enum logic [1:0] {
    DIR_NONE = 2'b00,
    DIR_RISE = 2'b01,  // negative -> positive, weight +1
    DIR_FALL = 2'b10   // positive -> negative, weight -1
  } dir_e;

  function automatic dir_e trans_dir(input logic prev_neg, input logic next_neg);
    if (prev_neg == next_neg) return DIR_NONE;
    return next_neg ? DIR_FALL : DIR_RISE;
  endfunction
endpackage

// File: rtl/ssd_window.sv
module ssd_window #(
  parameter int SW  = 8,
  parameter int SPS = 8,
  parameter int PW  = 3,
  parameter int HWW = 3,
  parameter int WSW = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic signed [SW-1:0]  sample_i,
  input  logic [PW-1:0]         phase_i,
  input  logic [HWW-1:0]        half_win_i,
  input  logic                  take_i,
  output logic signed [WSW-1:0] wsum_o,
  output logic signed [WSW-1:0] held_o,
  output logic                  held_vld_o
);
  localparam int HALF = SPS / 2;

  logic [HWW-1:0]        hw_eff;
  logic                  in_win, close;
  logic signed [WSW-1:0] smp_ext, sum_in;
  int                    ph_int, hw_int;

  always_comb begin
    hw_eff = (half_win_i > HWW'(HALF)) ? HWW'(HALF) : half_win_i;
    ph_int = int'(phase_i);
    hw_int = int'(hw_eff);
    in_win = (ph_int < hw_int) || (ph_int >= SPS - hw_int);
    close  = (hw_int == 0) ? (ph_int == 0) : (ph_int == hw_int - 1);
    smp_ext = {{(WSW-SW){sample_i[SW-1]}}, sample_i};
    sum_in  = in_win ? (wsum_o + smp_ext) : wsum_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wsum_o     <= '0;
      held_o     <= '0;
      held_vld_o <= 1'b0;
    end else begin
      if (take_i) held_vld_o <= 1'b0;
      if (valid_i) begin
        if (close) begin
          held_o     <= sum_in;
          held_vld_o <= 1'b1;
          wsum_o     <= '0;
        end else begin
          wsum_o <= sum_in;
        end
      end
    end
  end
endmodule

// File: rtl/ssd_transition.sv
module ssd_transition
  import ssd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dec_valid_i,
  input  logic dec_i,
  output dir_e dir_o,
  output logic dir_vld_o
);
  logic prev_neg, prev_vld;

  assign dir_o     = trans_dir(prev_neg, dec_i);
  assign dir_vld_o = dec_valid_i && prev_vld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_neg <= 1'b0;
      prev_vld <= 1'b0;
    end else if (dec_valid_i) begin
      prev_neg <= dec_i;
      prev_vld <= 1'b1;
    end
  end
endmodule

// File: rtl/ssd_accum.sv
module ssd_accum
  import ssd_pkg::*;
#(
  parameter int WSW = 12,
  parameter int LW  = 4,
  parameter int PRW = 13,
  parameter int EW  = 17
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  dir_e                  dir_i,
  input  logic                  dir_vld_i,
  input  logic signed [WSW-1:0] held_i,
  input  logic                  held_vld_i,
  input  logic [LW-1:0]         acc_len_i,
  output logic signed [PRW-1:0] prod_o,
  output logic                  prod_vld_o,
  output logic signed [EW-1:0]  err_o,
  output logic                  err_vld_o
);
  logic signed [PRW-1:0] held_ext;
  logic signed [EW-1:0]  acc, acc_nxt;
  logic [LW-1:0]         cnt, last;

  always_comb begin
    held_ext = {held_i[WSW-1], held_i};
    unique case (dir_i)
      DIR_RISE: prod_o = held_ext;
      DIR_FALL: prod_o = -held_ext;
      default:  prod_o = '0;
    endcase
    prod_vld_o = dir_vld_i && held_vld_i;
    acc_nxt    = acc + {{(EW-PRW){prod_o[PRW-1]}}, prod_o};
    last       = (acc_len_i == '0) ? '0 : acc_len_i - LW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc       <= '0;
      cnt       <= '0;
      err_o     <= '0;
      err_vld_o <= 1'b0;
    end else begin
      err_vld_o <= 1'b0;
      if (prod_vld_o) begin
        if (cnt >= last) begin
          err_o     <= acc_nxt;
          err_vld_o <= 1'b1;
          acc       <= '0;
          cnt       <= '0;
        end else begin
          acc <= acc_nxt;
          cnt <= cnt + LW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ssd_detector.sv
module ssd_detector
  import ssd_pkg::*;
#(
  parameter int SW  = 8,
  parameter int SPS = 8,
  parameter int PW  = $clog2(SPS),
  parameter int HWW = PW,
  parameter int LW  = 4,
  localparam int WSW = SW + $clog2(SPS + 1),
  localparam int PRW = WSW + 1,
  localparam int EW  = PRW + LW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [SW-1:0] sample_i,
  input  logic [PW-1:0]        phase_i,
  input  logic [HWW-1:0]       half_win_i,
  input  logic                 dec_valid_i,
  input  logic                 dec_i,
  input  logic [LW-1:0]        acc_len_i,
  output logic signed [EW-1:0] err_o,
  output logic                 err_vld_o
);
  logic signed [WSW-1:0] wsum, held;
  logic                  held_vld, dir_vld, prod_vld;
  logic signed [PRW-1:0] prod;
  dir_e                  dir;

  ssd_window #(.SW(SW), .SPS(SPS), .PW(PW), .HWW(HWW), .WSW(WSW)) i_window (
    .clk_i, .rst_ni, .valid_i, .sample_i, .phase_i, .half_win_i,
    .take_i    (dec_valid_i),
    .wsum_o    (wsum),
    .held_o    (held),
    .held_vld_o(held_vld)
  );

  ssd_transition i_trans (
    .clk_i, .rst_ni, .dec_valid_i, .dec_i,
    .dir_o    (dir),
    .dir_vld_o(dir_vld)
  );

  ssd_accum #(.WSW(WSW), .LW(LW), .PRW(PRW), .EW(EW)) i_accum (
    .clk_i, .rst_ni,
    .dir_i     (dir),
    .dir_vld_i (dir_vld),
    .held_i    (held),
    .held_vld_i(held_vld),
    .acc_len_i,
    .prod_o    (prod),
    .prod_vld_o(prod_vld),
    .err_o,
    .err_vld_o
  );
endmodule

// File: rtl/ssd_checker.sv
module ssd_checker #(
  parameter int SPS = 8,
  parameter int PW  = 3,
  parameter int HWW = 3,
  parameter int WSW = 12,
  parameter int PRW = 13,
  parameter int EW  = 17
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  valid_i,
  input logic [PW-1:0]         phase_i,
  input logic [HWW-1:0]        half_win_i,
  input logic                  dec_valid_i,
  input logic signed [WSW-1:0] wsum,
  input logic signed [WSW-1:0] held,
  input logic signed [PRW-1:0] prod,
  input logic                  prod_vld,
  input logic signed [EW-1:0]  err_o,
  input logic                  err_vld_o
);
  int lim;
  logic out_win;
  logic signed [PRW-1:0] h_ext;

  always_comb begin
    lim = (int'(half_win_i) > SPS / 2) ? SPS / 2 : int'(half_win_i);
    out_win = valid_i && (int'(phase_i) >= lim) && (int'(phase_i) < SPS - lim)
              && !(lim == 0 && phase_i == '0);
    h_ext = {held[WSW-1], held};
  end

  AST_OUT_OF_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_win |=> $stable(wsum)); // R2

  AST_TERM_MAGNITUDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prod_vld |-> (prod == '0 || prod == h_ext || prod == -h_ext)); // R4

  AST_READY_AFTER_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_vld_o |-> $past(dec_valid_i)); // R7

  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_vld_o && !$past(!rst_ni) |-> $stable(err_o)); // R7
endmodule

bind ssd_detector ssd_checker #(
  .SPS(SPS), .PW(PW), .HWW(HWW), .WSW(WSW), .PRW(PRW), .EW(EW)
) i_ssd_checker (
  .clk_i, .rst_ni, .valid_i, .phase_i, .half_win_i, .dec_valid_i,
  .wsum, .held, .prod, .prod_vld, .err_o, .err_vld_o
);

// File: tb/test_ssd_detector.sv
module test_ssd_detector;
  localparam int CLK_P = 10;
  localparam int SW = 8, SPS = 8, PW = 3, HWW = 3, LW = 4;
  localparam int WSW = SW + $clog2(SPS + 1);
  localparam int EW = WSW + 1 + LW;
  localparam int NS = 40;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic signed [SW-1:0] sample_i = '0;
  logic [PW-1:0] phase_i = '0;
  logic [HWW-1:0] half_win_i = '0;
  logic dec_valid_i = 1'b0;
  logic dec_i = 1'b0;
  logic [LW-1:0] acc_len_i = '0;
  logic signed [EW-1:0] err_o;
  logic err_vld_o;

  always #(CLK_P/2) clk = ~clk;

  ssd_detector #(.SW(SW), .SPS(SPS), .PW(PW), .HWW(HWW), .LW(LW)) i_ssd_detector (
    .clk_i(clk), .rst_ni, .valid_i, .sample_i, .phase_i, .half_win_i,
    .dec_valid_i, .dec_i, .acc_len_i, .err_o, .err_vld_o
  );

  int n_run = 0, n_fail = 0;
  logic [31:0] st = 32'h1234_5678;
  int samp[NS][SPS];
  bit dec[NS];
  bit emit[NS];
  int exp_q[$];

  task automatic chk(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] xs(logic [31:0] s);
    s ^= s << 13; s ^= s >> 17; s ^= s << 5;
    return s;
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0; valid_i = 1'b0; dec_valid_i = 1'b0;
    @(negedge clk);
    chk(err_vld_o == 1'b0 && err_o == '0, "R1 reset state", int'(err_vld_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(err_vld_o == 1'b0 && err_o == '0, "R1 after release", int'($signed(err_o)), 0);
  endtask

  task automatic run_cfg(int hw, int len, int pm);
    int h, leff, acc, cnt, w, d, got, nexp, sp, sn;
    bit pend;
    string tg;
    h = (hw > SPS/2) ? SPS/2 : hw;
    leff = (len == 0) ? 1 : len;
    tg = (hw == 0) ? "R8" : (hw > SPS/2) ? "R3" : (pm == 2) ? "R4" : "R2";
    for (int k = 0; k < NS; k++) begin
      for (int p = 0; p < SPS; p++) begin
        st = xs(st);
        samp[k][p] = int'($signed(st[7:0]));
      end
      st = xs(st);
      dec[k] = (pm == 0) ? st[11] : (pm == 1) ? k[0] : 1'b1;
      emit[k] = 1'b0;
    end
    exp_q.delete();
    acc = 0; cnt = 0;
    // first decision records a sign only
    for (int k = 1; k < NS; k++) begin
      w = 0;
      for (int p = 0; p < SPS; p++) begin
        if (p >= SPS - h) w += samp[k-1][p];
        if (p < h) w += samp[k][p];
      end
      sp = dec[k-1] ? -1 : 1;
      sn = dec[k] ? -1 : 1;
      d = (sn - sp) / 2;
      acc += w * d;
      if (cnt == leff - 1) begin
        exp_q.push_back(acc); emit[k] = 1'b1; acc = 0; cnt = 0;
      end else cnt++;
    end
    nexp = exp_q.size();
    half_win_i = HWW'(hw);
    acc_len_i = LW'(len);
    do_reset();
    got = 0; pend = 1'b0;
    for (int k = 0; k <= NS; k++) begin
      for (int p = 0; p < SPS; p++) begin
        @(negedge clk);
        if (err_vld_o || pend)
          chk(err_vld_o == pend, "R7 ready timing", int'(err_vld_o), int'(pend));
        if (err_vld_o && exp_q.size() > 0) begin
          chk($signed(err_o) == exp_q[0], tg, int'($signed(err_o)), exp_q[0]);
          void'(exp_q.pop_front());
          got++;
        end
        if (k == NS) begin
          valid_i = 1'b0; dec_valid_i = 1'b0; pend = 1'b0;
        end else begin
          valid_i = 1'b1;
          sample_i = SW'(samp[k][p]);
          phase_i = PW'(p);
          dec_valid_i = (p == SPS - 1);
          dec_i = dec[k];
          pend = (p == SPS - 1) && emit[k];
        end
      end
    end
    chk(got == nexp, "R5 R6 word count", got, nexp);
  endtask

  initial begin
    for (int pm = 0; pm < 3; pm++)
      for (int hw = 0; hw < 8; hw++) begin
        run_cfg(hw, 0, pm);
        run_cfg(hw, 1, pm);
        run_cfg(hw, 3, pm);
      end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule